// File: doc/BRIEF.md
# EPP Host Read Cycle Controller

This block is the host-side sequencer for byte-wide read transfers on an enhanced parallel port. A CPU-side request picks a data read or an address read. The controller drives the active-low write, data-strobe and address-strobe lines. It leaves its side of the 8-bit bidirectional bus in high impedance and then holds the strobe low while the peripheral keeps its wait line low. When the peripheral raises wait, the bus byte is registered and the strobe is released. A loadable time-out ends a cycle that stalls for too long.

Requests arrive on a valid/ready channel. `req_ready` is high only when the controller is idle, the direction control bit is 1 and no response is waiting. A request offered at any other time is neither taken nor lost: the host keeps `req_valid` high until it sees ready. Results leave on a second valid/ready channel. Once `rsp_valid` is raised, it stays high and its payload stays unchanged until `rsp_ready` is seen high at a clock edge. While a result is waiting, no new request is accepted. That is how response back-pressure reaches the request side.

The peripheral wait and interrupt inputs each pass through a two-flop synchronizer before use. The write line may be forced from the legacy control path. The peripheral reset output follows a host control bit.

Top module: `epp_host_read`

## Requirements
- R1: After reset, `n_datastb` and `n_addrstb` are 1, `rsp_valid` is 0 and `timeout_sticky` is 0.
- R2: An accepted request with `req_is_addr`=0 drives only `n_datastb` low. One with `req_is_addr`=1 drives only `n_addrstb` low. The two strobes are never low together.
- R3: A strobe goes low no earlier than the second clock after acceptance, and only while `pd_oe`=0. With the override off, `n_write` equals `cfg_dir`, so it is 1 during reads.
- R4: A request is accepted (`req_valid` and `req_ready` both 1 at an edge) only while idle with `cfg_dir`=1 and no response waiting. When `cfg_dir`=0, `req_ready` stays 0 and no strobe goes low.
- R5: While `nwait_n` stays low the strobe stays low. The clock on which the synchronized wait is first seen high captures `pd_i`. At that clock the strobe returns high, `rsp_valid` rises with `rsp_data` equal to the captured byte, and `rsp_timeout`=0.
- R6: With `nwait_n` held low, the strobe stays low for exactly `cfg_timeout`+1 cycles. It is then released and a response is given with `rsp_timeout`=1 and `rsp_data`=0. `timeout_sticky` is set at that clock and stays set until a cycle with `timeout_clr`=1.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_data` and `rsp_timeout` hold their values, and `req_ready` is 0.
- R8: When `spp_ovr_en`=1, `n_write` equals `spp_ovr_val`. No other output is affected.
- R9: `intr_o` follows `intr_in` without inversion, delayed by two clocks.
- R10: `n_reset_o` is the inverse of `cfg_reset_periph`, registered one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir | input | 1 | Direction control bit, 1 = reverse (read) |
| cfg_timeout | input | TMO_W | Wait-state limit, loaded at strobe start |
| cfg_reset_periph | input | 1 | 1 requests peripheral reset |
| spp_ovr_en | input | 1 | Enables legacy override of the write line |
| spp_ovr_val | input | 1 | Override value for the write line |
| timeout_clr | input | 1 | Clears the sticky time-out bit |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request can be accepted |
| req_is_addr | input | 1 | 0 = data read, 1 = address read |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Host accepts the result |
| rsp_data | output | DATA_W | Captured byte (0 on time-out) |
| rsp_timeout | output | 1 | Result ended by time-out |
| timeout_sticky | output | 1 | Sticky time-out status |
| pd_i | input | DATA_W | Parallel bus input |
| pd_oe | output | 1 | Host bus drive enable, 0 = high impedance |
| n_write | output | 1 | Active-low write line |
| n_datastb | output | 1 | Active-low data strobe |
| n_addrstb | output | 1 | Active-low address strobe |
| nwait_n | input | 1 | Active-low peripheral wait |
| n_reset_o | output | 1 | Active-low peripheral reset |
| intr_in | input | 1 | Peripheral interrupt, active high |
| intr_o | output | 1 | Synchronized interrupt to the host |

## Verification
The bound checker watches, on every cycle, that both strobes are never low together, that a strobe is low only while the bus is released, that an accepting idle state shows both strobes high, and that a stalled response holds its payload. It also checks that every response appears in the same clock as the strobe release, and that a time-out response arrives with the sticky bit set. The directed scenarios show what a single-cycle property cannot: the captured byte value, the exact strobe length of `cfg_timeout`+1 cycles under a stall, and requests ignored while the direction bit is 0. They also cover the override of the write line, the interrupt's two-clock latency and the registered peripheral reset.

// File: rtl/epp_rd_pkg.sv
package epp_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_RESP   = 2'd3
  } rd_state_e;

endpackage

// File: rtl/epp_rd_sync.sv
module epp_rd_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= d_i;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/epp_rd_timer.sv
module epp_rd_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/epp_rd_fsm.sv
module epp_rd_fsm
  import epp_rd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dir,
  input  logic              req_valid,
  input  logic              req_is_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_timeout,
  input  logic              wait_hi,
  input  logic [DATA_W-1:0] pd_i,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic              tmr_dec,
  output logic              tmo_event,
  output logic              n_datastb,
  output logic              n_addrstb
);

  rd_state_e         state_q, state_d;
  logic              is_addr_q;
  logic [DATA_W-1:0] data_q;
  logic              tmo_q;
  logic              accept;
  logic              finish_ok;
  logic              finish_tmo;

  assign req_ready = (state_q == ST_IDLE) && cfg_dir;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (state_q == ST_RESP);

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_dec    = 1'b0;
    finish_ok  = 1'b0;
    finish_tmo = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP: begin
        tmr_load = 1'b1;
        state_d  = ST_STROBE;
      end
      ST_STROBE: begin
        if (wait_hi) begin
          finish_ok = 1'b1;
          state_d   = ST_RESP;
        end else if (tmr_zero) begin
          finish_tmo = 1'b1;
          state_d    = ST_RESP;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_RESP:   if (rsp_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tmo_event = finish_tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      is_addr_q <= 1'b0;
      data_q    <= '0;
      tmo_q     <= 1'b0;
      n_datastb <= 1'b1;
      n_addrstb <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept) is_addr_q <= req_is_addr;
      if (finish_ok) begin
        data_q <= pd_i;
        tmo_q  <= 1'b0;
      end else if (finish_tmo) begin
        data_q <= '0;
        tmo_q  <= 1'b1;
      end
      n_datastb <= !((state_d == ST_STROBE) && !is_addr_q);
      n_addrstb <= !((state_d == ST_STROBE) &&  is_addr_q);
    end
  end

  assign rsp_data    = data_q;
  assign rsp_timeout = tmo_q;

endmodule

// File: rtl/epp_host_read.sv
module epp_host_read #(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dir,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic              cfg_reset_periph,
  input  logic              spp_ovr_en,
  input  logic              spp_ovr_val,
  input  logic              timeout_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_timeout,
  output logic              timeout_sticky,
  input  logic [DATA_W-1:0] pd_i,
  output logic              pd_oe,
  output logic              n_write,
  output logic              n_datastb,
  output logic              n_addrstb,
  input  logic              nwait_n,
  output logic              n_reset_o,
  input  logic              intr_in,
  output logic              intr_o
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] async_in, synced;
  logic              wait_hi;
  logic              tmr_zero, tmr_load, tmr_dec, tmo_event;
  logic              sticky_q, nrst_q;

  assign async_in = {intr_in, nwait_n};

  epp_rd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (async_in),
    .q_o   (synced)
  );

  assign wait_hi = synced[0];
  assign intr_o  = synced[1];

  epp_rd_timer #(.W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (cfg_timeout),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  epp_rd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dir     (cfg_dir),
    .req_valid   (req_valid),
    .req_is_addr (req_is_addr),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_timeout (rsp_timeout),
    .wait_hi     (wait_hi),
    .pd_i        (pd_i),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_dec     (tmr_dec),
    .tmo_event   (tmo_event),
    .n_datastb   (n_datastb),
    .n_addrstb   (n_addrstb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      nrst_q   <= 1'b1;
    end else begin
      if (tmo_event)        sticky_q <= 1'b1;
      else if (timeout_clr) sticky_q <= 1'b0;
      nrst_q <= !cfg_reset_periph;
    end
  end

  assign timeout_sticky = sticky_q;
  assign n_reset_o      = nrst_q;
  assign pd_oe          = !cfg_dir;
  assign n_write        = spp_ovr_en ? spp_ovr_val : cfg_dir;

endmodule

// File: rtl/epp_host_read_chk.sv
module epp_host_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_timeout,
  input logic              timeout_sticky,
  input logic              pd_oe,
  input logic              n_datastb,
  input logic              n_addrstb
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!n_datastb && !n_addrstb)); // R2

  AST_STROBE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!n_datastb || !n_addrstb) |-> !pd_oe); // R3

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (n_datastb && n_addrstb && !rsp_valid)); // R4

  AST_RSP_STROBE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (n_datastb && n_addrstb)); // R5

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_timeout) |-> timeout_sticky); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_timeout))); // R7

endmodule

bind epp_host_read epp_host_read_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_data       (rsp_data),
  .rsp_timeout    (rsp_timeout),
  .timeout_sticky (timeout_sticky),
  .pd_oe          (pd_oe),
  .n_datastb      (n_datastb),
  .n_addrstb      (n_addrstb)
);

// File: tb/tb_epp_host_read.sv
module tb_epp_host_read;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_dir = 1'b1;
  logic [TW-1:0] cfg_timeout = 16'd100;
  logic          cfg_reset_periph = 1'b0;
  logic          spp_ovr_en = 1'b0, spp_ovr_val = 1'b0;
  logic          timeout_clr = 1'b0;
  logic          req_valid = 1'b0, req_is_addr = 1'b0;
  logic          req_ready;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          rsp_timeout, timeout_sticky;
  logic [DW-1:0] pd_i = '0;
  logic          pd_oe, n_write, n_datastb, n_addrstb;
  logic          nwait_n = 1'b0;
  logic          n_reset_o;
  logic          intr_in = 1'b0;
  logic          intr_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epp_host_read dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_timeout(cfg_timeout),
    .cfg_reset_periph(cfg_reset_periph), .spp_ovr_en(spp_ovr_en),
    .spp_ovr_val(spp_ovr_val), .timeout_clr(timeout_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_addr(req_is_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_timeout(rsp_timeout), .timeout_sticky(timeout_sticky),
    .pd_i(pd_i), .pd_oe(pd_oe), .n_write(n_write), .n_datastb(n_datastb),
    .n_addrstb(n_addrstb), .nwait_n(nwait_n), .n_reset_o(n_reset_o),
    .intr_in(intr_in), .intr_o(intr_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic is_addr);
    @(negedge clk);
    req_valid   = 1'b1;
    req_is_addr = is_addr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 n_datastb", n_datastb, 1);
    check("R1 n_addrstb", n_addrstb, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 timeout_sticky", timeout_sticky, 0);
  endtask

  task automatic t_read(input logic is_addr, input logic [7:0] val);
    int strobe_seen;
    nwait_n = 1'b0;
    send(is_addr);
    // send returns one negedge after acceptance: SETUP state, strobe still high
    check("R3 strobe not yet low", is_addr ? n_addrstb : n_datastb, 1);
    strobe_seen = 0;
    while ((is_addr ? n_addrstb : n_datastb) != 1'b0) @(negedge clk);
    check("R2 other strobe high", is_addr ? n_datastb : n_addrstb, 1);
    check("R3 pd_oe released", pd_oe, 0);
    check("R3 n_write high", n_write, 1);
    pd_i = val;
    repeat (4) begin
      @(negedge clk);
      if ((is_addr ? n_addrstb : n_datastb) == 1'b0) strobe_seen++;
    end
    check("R5 strobe held while wait low", strobe_seen, 4);
    nwait_n = 1'b1;
    wait_rsp();
    check("R5 rsp_data", rsp_data, val);
    check("R5 rsp_timeout", rsp_timeout, 0);
    check("R5 strobe released", is_addr ? n_addrstb : n_datastb, 1);
    pd_i = 8'h00;
    @(negedge clk);
    nwait_n = 1'b0;
    check("R5 rsp consumed", rsp_valid, 0);
  endtask

  task automatic t_timeout();
    int low_cnt;
    cfg_timeout = 16'd5;
    nwait_n = 1'b0;
    pd_i = 8'hEE;
    low_cnt = 0;
    send(1'b0);
    while (!rsp_valid) begin
      if (!n_datastb) low_cnt++;
      @(negedge clk);
    end
    check("R6 strobe low cycles", low_cnt, 6);
    check("R6 rsp_timeout", rsp_timeout, 1);
    check("R6 rsp_data zero", rsp_data, 0);
    check("R6 sticky set", timeout_sticky, 1);
    check("R6 strobe released", n_datastb, 1);
    repeat (3) @(negedge clk);
    check("R6 sticky holds", timeout_sticky, 1);
    timeout_clr = 1'b1;
    @(negedge clk);
    timeout_clr = 1'b0;
    check("R6 sticky cleared", timeout_sticky, 0);
    cfg_timeout = 16'd100;
    pd_i = 8'h00;
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    nwait_n = 1'b0;
    pd_i = 8'h3C;
    send(1'b1);
    repeat (3) @(negedge clk);
    nwait_n = 1'b1;
    wait_rsp();
    check("R7 first data", rsp_data, 8'h3C);
    pd_i = 8'hFF;
    repeat (4) @(negedge clk);
    check("R7 valid held", rsp_valid, 1);
    check("R7 data held", rsp_data, 8'h3C);
    check("R7 timeout held", rsp_timeout, 0);
    check("R7 req_ready low", req_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R7 released", rsp_valid, 0);
    nwait_n = 1'b0;
    pd_i = 8'h00;
  endtask

  task automatic t_dir_off();
    int low_seen;
    cfg_dir = 1'b0;
    req_valid = 1'b1;
    low_seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (req_ready || !n_datastb || !n_addrstb) low_seen++;
    end
    check("R4 no accept/strobe with dir 0", low_seen, 0);
    check("R4 pd_oe driven with dir 0", pd_oe, 1);
    check("R3 n_write follows dir", n_write, 0);
    req_valid = 1'b0;
    cfg_dir = 1'b1;
    @(negedge clk);
    check("R4 ready back", req_ready, 1);
  endtask

  task automatic t_override();
    spp_ovr_en = 1'b1;
    spp_ovr_val = 1'b0;
    #1;
    check("R8 n_write forced low", n_write, 0);
    check("R8 strobes untouched", {n_datastb, n_addrstb}, 3);
    spp_ovr_val = 1'b1;
    #1;
    check("R8 n_write forced high", n_write, 1);
    spp_ovr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_intr_reset();
    intr_in = 1'b1;
    @(negedge clk);
    check("R9 intr after 1 clk", intr_o, 0);
    @(negedge clk);
    check("R9 intr after 2 clk", intr_o, 1);
    intr_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 intr low again", intr_o, 0);
    cfg_reset_periph = 1'b1;
    @(negedge clk);
    check("R10 n_reset low", n_reset_o, 0);
    cfg_reset_periph = 1'b0;
    @(negedge clk);
    check("R10 n_reset high", n_reset_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read(1'b0, 8'hA5);
    t_read(1'b1, 8'h5A);
    t_timeout();
    t_backpressure();
    t_dir_off();
    t_override();
    t_intr_reset();
    t_read(1'b0, 8'hC3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule